// File: doc/BRIEF.md
# Circular and Bit-Reversed Address Generator

This block generates memory addresses for a signal-processing datapath. It holds a single pointer register. On each step request it moves that pointer under one of three rules. Linear mode adds or subtracts a step amount. Circular mode walks a buffer bounded by a programmable lower and upper address. Bit-reverse mode runs a counter and presents it with its low bits mirrored, which gives the shuffled order that FFT stages need.

Three configuration registers are loaded through a plain write port: the buffer lower bound, the buffer upper bound, and the reverse width. Any accepted write puts the pointer back at the lower bound. This lets software or a sequencer start a new pass with one write. The effective address and a one-cycle wrap pulse are the only outputs. The address is a direct function of the pointer and the current mode, so no extra latency is added.

Top module: `agu_addr_gen`

## Requirements
- R1: After reset the lower bound, the upper bound and the pointer are all 0, the reverse width is 1, `addr` is 0 and `wrap` is 0.
- R2: A configuration write (`cfg_we`=1) with `cfg_sel` 0 sets the lower bound, 1 sets the upper bound, and 2 sets the reverse width from `cfg_wdata[3:0]`. After any of these writes, the pointer equals the lower bound in the next cycle; for a write to the lower bound, that is the newly written value. A write also takes priority over a step request in the same cycle.
- R3: A write with `cfg_sel` 3 changes no register and leaves the pointer unchanged.
- R4: In linear mode (`mode` 0 or 3), a step adds `step_amt` to the pointer when `dir_down`=0 and subtracts it when `dir_down`=1, modulo 2^AW. The output `addr` equals the pointer.
- R5: In circular mode (`mode` 1) with `dir_down`=0, a step moves the pointer to the upper bound's successor rule: the pointer becomes the lower bound if it equals the upper bound, and the pointer plus 1 otherwise.
- R6: In circular mode with `dir_down`=1, a step makes the pointer the upper bound if it equals the lower bound, and the pointer minus 1 otherwise.
- R7: `wrap` is 1 in the cycle after a circular step that reloaded the pointer from a bound, and 0 in every other cycle.
- R8: In bit-reverse mode (`mode` 2), a step moves the pointer by 1, up or down according to `dir_down`. `addr` is the pointer with its low W bits mirrored, bit i taking pointer bit W-1-i. Here W is the reverse width, and the bits above W pass through unchanged. With W=3, the pointer values 0 to 7 give 0, 4, 2, 6, 1, 5, 3, 7.
- R9: A written reverse width of 0 acts as 1, and any value above 10 acts as 10.
- R10: Without a step request or a configuration write, the pointer holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 lower bound, 1 upper bound, 2 reverse width, 3 none |
| cfg_wdata | input | AW (12) | Configuration write data |
| step_req | input | 1 | Advance the pointer this cycle |
| mode | input | 2 | 0 linear, 1 circular, 2 bit-reverse, 3 linear |
| dir_down | input | 1 | 1 steps downward, 0 upward |
| step_amt | input | AW (12) | Linear step size |
| addr | output | AW (12) | Effective address |
| wrap | output | 1 | One-cycle pulse after a circular reload |

## Verification
The assertions assume `mode` stays fixed between a step and the cycle that follows it, because the wrap check looks back at the mode of the step that caused it. They also assume the buffer bounds do not change during a circular step; this holds because every bound change is itself a write that overrides the step. The stimulus changes mode only when no step is pending. It moves the bounds only through the write port, so every run starts from a freshly reset pointer. The circular sweeps start inside the buffer, so the equality checks see every address between the bounds.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    AGU_LINEAR  = 2'd0,
    AGU_CIRC    = 2'd1,
    AGU_BITREV  = 2'd2,
    AGU_LINEAR2 = 2'd3
  } agu_mode_e;

  typedef enum logic [1:0] {
    SEL_BASE   = 2'd0,
    SEL_LIMIT  = 2'd1,
    SEL_RWIDTH = 2'd2,
    SEL_NONE   = 2'd3
  } agu_sel_e;
endpackage

// File: rtl/agu_cfg_regs.sv
module agu_cfg_regs
  import agu_pkg::*;
#(
  parameter int AW     = 12,
  parameter int RW_MAX = 10,
  parameter int RWW    = $clog2(RW_MAX + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [1:0]     sel,
  input  logic [AW-1:0]  wdata,
  output logic [AW-1:0]  base_q,
  output logic [AW-1:0]  limit_q,
  output logic [RWW-1:0] rw_q,
  output logic           reload,
  output logic [AW-1:0]  reload_val
);
  agu_sel_e       sel_e;
  logic [RWW-1:0] rw_raw;
  logic [RWW-1:0] rw_clamped;

  assign sel_e  = agu_sel_e'(sel);
  assign rw_raw = wdata[RWW-1:0];
  assign reload = we && (sel_e != SEL_NONE);
  assign reload_val = (sel_e == SEL_BASE) ? wdata : base_q;

  always_comb begin
    if (rw_raw == '0)
      rw_clamped = RWW'(1);
    else if (rw_raw > RWW'(RW_MAX))
      rw_clamped = RWW'(RW_MAX);
    else
      rw_clamped = rw_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      limit_q <= '0;
      rw_q    <= RWW'(1);
    end else if (we) begin
      case (sel_e)
        SEL_BASE:   base_q  <= wdata;
        SEL_LIMIT:  limit_q <= wdata;
        SEL_RWIDTH: rw_q    <= rw_clamped;
        default:    ;
      endcase
    end
  end

  a_r9_width_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_q >= RWW'(1)) && (rw_q <= RWW'(RW_MAX)));

  a_r3_none_select_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel_e == SEL_NONE) |=> ($stable(base_q) && $stable(limit_q) && $stable(rw_q)));
endmodule

// File: rtl/agu_next_ptr.sv
module agu_next_ptr
  import agu_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic [AW-1:0] ptr,
  input  logic [1:0]    mode,
  input  logic          dir_down,
  input  logic [AW-1:0] step_amt,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] limit,
  output logic [AW-1:0] nxt,
  output logic          bound_hit
);
  agu_mode_e mode_e;
  logic      at_limit;
  logic      at_base;

  assign mode_e   = agu_mode_e'(mode);
  assign at_limit = (ptr == limit);
  assign at_base  = (ptr == base);

  always_comb begin
    bound_hit = 1'b0;
    unique case (mode_e)
      AGU_CIRC: begin
        if (!dir_down) begin
          if (at_limit) begin
            nxt       = base;
            bound_hit = 1'b1;
          end else begin
            nxt = ptr + AW'(1);
          end
        end else begin
          if (at_base) begin
            nxt       = limit;
            bound_hit = 1'b1;
          end else begin
            nxt = ptr - AW'(1);
          end
        end
      end
      AGU_BITREV: nxt = dir_down ? ptr - AW'(1) : ptr + AW'(1);
      default:    nxt = dir_down ? ptr - step_amt : ptr + step_amt;
    endcase
  end
endmodule

// File: rtl/agu_bitrev.sv
module agu_bitrev #(
  parameter int AW     = 12,
  parameter int RW_MAX = 10,
  parameter int RWW    = $clog2(RW_MAX + 1)
) (
  input  logic [AW-1:0]  din,
  input  logic [RWW-1:0] width,
  output logic [AW-1:0]  dout
);
  always_comb begin
    dout = din;
    for (int i = 0; i < RW_MAX; i++) begin
      for (int j = 0; j < RW_MAX; j++) begin
        if ((i < int'(width)) && (j == int'(width) - 1 - i))
          dout[i] = din[j];
      end
    end
  end
endmodule

// File: rtl/agu_addr_gen.sv
module agu_addr_gen
  import agu_pkg::*;
#(
  parameter int AW     = 12,
  parameter int RW_MAX = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          step_req,
  input  logic [1:0]    mode,
  input  logic          dir_down,
  input  logic [AW-1:0] step_amt,
  output logic [AW-1:0] addr,
  output logic          wrap
);
  localparam int RWW = $clog2(RW_MAX + 1);

  logic [AW-1:0]  ptr_q;
  logic [AW-1:0]  base_q, limit_q, reload_val, nxt, rev_addr;
  logic [RWW-1:0] rw_q;
  logic           reload, bound_hit;

  agu_cfg_regs #(.AW(AW), .RW_MAX(RW_MAX), .RWW(RWW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .base_q(base_q), .limit_q(limit_q), .rw_q(rw_q),
    .reload(reload), .reload_val(reload_val)
  );

  agu_next_ptr #(.AW(AW)) u_next (
    .ptr(ptr_q), .mode(mode), .dir_down(dir_down), .step_amt(step_amt),
    .base(base_q), .limit(limit_q), .nxt(nxt), .bound_hit(bound_hit)
  );

  agu_bitrev #(.AW(AW), .RW_MAX(RW_MAX), .RWW(RWW)) u_rev (
    .din(ptr_q), .width(rw_q), .dout(rev_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      wrap  <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (reload) begin
        ptr_q <= reload_val;
      end else if (step_req) begin
        ptr_q <= nxt;
        wrap  <= bound_hit;
      end
    end
  end

  assign addr = (agu_mode_e'(mode) == AGU_BITREV) ? rev_addr : ptr_q;

  a_r2_write_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (ptr_q == base_q));

  a_r5_up_wraps_to_base: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !cfg_we && mode == 2'd1 && !dir_down && ptr_q == limit_q)
      |=> (ptr_q == base_q && wrap));

  a_r6_down_wraps_to_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !cfg_we && mode == 2'd1 && dir_down && ptr_q == base_q)
      |=> (ptr_q == limit_q && wrap));

  a_r7_wrap_needs_circ_step: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> ($past(step_req) && $past(mode) == 2'd1));

  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_req && !cfg_we) |=> ($stable(ptr_q) && !wrap));
endmodule

// File: tb/test_agu_addr_gen.sv
module test_agu_addr_gen;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          step_req = 1'b0;
  logic [1:0]    mode = '0;
  logic          dir_down = 1'b0;
  logic [AW-1:0] step_amt = '0;
  logic [AW-1:0] addr;
  logic          wrap;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [AW-1:0] m_ptr = '0, m_base = '0, m_limit = '0;
  int            m_rw = 1;
  logic          m_wrap = 1'b0;

  always #4 clk = ~clk;

  agu_addr_gen #(.AW(AW), .RW_MAX(10)) i_agu_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .step_req(step_req), .mode(mode),
    .dir_down(dir_down), .step_amt(step_amt), .addr(addr), .wrap(wrap)
  );

  function automatic logic [AW-1:0] mirror(logic [AW-1:0] v, int w);
    logic [AW-1:0] r = v;
    for (int i = 0; i < w; i++) r[i] = v[w-1-i];
    return r;
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return (mode == 2'd2) ? mirror(m_ptr, m_rw) : m_ptr;
  endfunction

  task automatic check(string req);
    logic [AW-1:0] ea = exp_addr();
    n_chk++;
    if (addr !== ea || wrap !== m_wrap) begin
      n_bad++;
      $display("FAIL %s: addr=%0d wrap=%0b expected addr=%0d wrap=%0b",
               req, addr, wrap, ea, m_wrap);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] d, input bit with_step, string req);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; step_req = with_step;
    @(negedge clk);
    cfg_we = 1'b0; step_req = 1'b0;
    m_wrap = 1'b0;
    if (sel != 2'd3) begin
      if (sel == 2'd0) m_base = d;
      if (sel == 2'd1) m_limit = d;
      if (sel == 2'd2) begin
        m_rw = int'(d[3:0]);
        if (m_rw == 0) m_rw = 1;
        if (m_rw > 10) m_rw = 10;
      end
      m_ptr = m_base;
    end
    check(req);
  endtask

  task automatic step(input logic [1:0] md, input logic dn, input logic [AW-1:0] amt, string req);
    @(negedge clk);
    mode = md; dir_down = dn; step_amt = amt; step_req = 1'b1;
    @(negedge clk);
    step_req = 1'b0;
    m_wrap = 1'b0;
    case (md)
      2'd1: begin
        if (!dn) begin
          if (m_ptr == m_limit) begin m_ptr = m_base; m_wrap = 1'b1; end
          else m_ptr = m_ptr + 1'b1;
        end else begin
          if (m_ptr == m_base) begin m_ptr = m_limit; m_wrap = 1'b1; end
          else m_ptr = m_ptr - 1'b1;
        end
      end
      2'd2: m_ptr = dn ? m_ptr - 1'b1 : m_ptr + 1'b1;
      default: m_ptr = dn ? m_ptr - amt : m_ptr + amt;
    endcase
    check(req);
  endtask

  task automatic circ_run(input logic [AW-1:0] b, input logic [AW-1:0] l, input logic dn);
    cfg(2'd1, l, 0, "R2");
    cfg(2'd0, b, 0, "R2");
    for (int k = 0; k < 2 * (int'(l) - int'(b) + 1) + 3; k++)
      step(2'd1, dn, '0, dn ? "R6/R7" : "R5/R7");
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    @(negedge clk);
    check("R10");

    // R5/R6/R7 circular sweeps
    circ_run(12'd5, 12'd9, 1'b0);
    circ_run(12'd5, 12'd9, 1'b1);
    circ_run(12'd0, 12'd0, 1'b0);
    circ_run(12'd4090, 12'd4095, 1'b0);
    circ_run(12'd100, 12'd103, 1'b1);
    @(negedge clk); m_wrap = 1'b0; check("R7 pulse ends");

    // R4 linear with modulo wrap
    cfg(2'd0, 12'd4093, 0, "R2");
    for (int k = 0; k < 6; k++) step(2'd0, 1'b0, 12'd3, "R4");
    for (int k = 0; k < 6; k++) step(2'd3, 1'b1, 12'd5, "R4");
    @(negedge clk); check("R10");

    // R3 unused select ignored
    cfg(2'd3, 12'd77, 0, "R3");
    // R2 write beats a step
    cfg(2'd0, 12'd200, 1, "R2");

    // R8 three-bit table
    cfg(2'd0, 12'd0, 0, "R2");
    cfg(2'd2, 12'd3, 0, "R2");
    mode = 2'd2;
    for (int k = 0; k < 8; k++) begin
      logic [AW-1:0] tbl;
      tbl = (k[0] ? 12'd4 : 12'd0) + (k[1] ? 12'd2 : 12'd0) + (k[2] ? 12'd1 : 12'd0);
      n_chk++;
      if (addr !== tbl) begin
        n_bad++;
        $display("FAIL R8 table: addr=%0d expected=%0d", addr, tbl);
      end
      step(2'd2, 1'b0, '0, "R8");
    end

    // R8 sweep over every width, upward and downward
    for (int w = 1; w <= 10; w++) begin
      cfg(2'd2, AW'(w), 0, "R8");
      for (int k = 0; k < (1 << w) + 2; k++) step(2'd2, 1'b0, '0, "R8");
      for (int k = 0; k < 4; k++) step(2'd2, 1'b1, '0, "R8");
    end

    // R8 upper bits pass through
    cfg(2'd0, 12'h404, 0, "R2");
    cfg(2'd2, 12'd3, 0, "R8");
    for (int k = 0; k < 10; k++) step(2'd2, 1'b0, '0, "R8 upper");

    // R9 clamping
    cfg(2'd2, 12'd0, 0, "R9");
    for (int k = 0; k < 3; k++) step(2'd2, 1'b0, '0, "R9 low");
    cfg(2'd2, 12'd15, 0, "R9");
    for (int k = 0; k < 20; k++) step(2'd2, 1'b0, '0, "R9 high");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule